// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes stereo PCM audio from a three-wire serial link and turns it into parallel left and right samples. The three wires are a bit clock, a word clock and a data line. All three are sampled by a faster system clock, and the block finds the rising edges of the bit clock itself. On each rising bit-clock edge it takes one data bit, always MSB first. One static input chooses the framing. When it is high the framing is I2S. When it is low the framing is 16-bit right-justified. The same input also chooses the variant of the short-sync framing.

The block measures how long each word-clock level lasts. From that it recognises two special cases on every frame. A high pulse of four bit clocks or fewer is a sync pulse: a 16-bit left word and then a 16-bit right word follow it. In I2S, phases of exactly 16 bit clocks carry packed 16-bit words. Every sample leaves the block 24 bits wide and left-aligned. Bits beyond 24 are dropped. Shorter words have zeros below them.

Completed pairs leave through a valid/ready output. The serial link cannot be stalled, so back-pressure works like this. A pair that has not been taken stays on the outputs, with `out_valid` high. If a newer pair completes first, it replaces the older one.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and both sample outputs are 0 until a pair is complete.
- R2: With `fmt_i2s` high, a word-clock low phase carries the left word and a high phase carries the right word. The MSB is taken on the second rising bit-clock edge after the word-clock change (counting the edge that first sees the new level as the first). A 24-bit word in a phase of 24 or more bit clocks is output unchanged.
- R3: In I2S, when a word is longer than 24 bits only its first 24 bits appear on the output.
- R4: In I2S, a word shorter than 24 bits, sent zero-padded in a phase of at least 24 bit clocks, is output with zeros in its low bits.
- R5: In I2S, when a phase lasts exactly 16 bit clocks, the 16 bits taken appear in output bits [23:8], and bits [7:0] are 0.
- R6: With `fmt_i2s` low, a word-clock high phase is left and a low phase is right. The 16 bits taken on the last 16 rising edges of a phase (LSB on the last edge before the change) appear in output bits [23:8], and bits [7:0] are 0.
- R7: A word-clock high pulse of 1 to 4 bit clocks marks a sync frame. 32 bits follow it: the left word and then the right word, 16 bits each. Each is output in bits [23:8] with bits [7:0] at 0.
- R8: In a sync frame, `fmt_i2s` low makes the left MSB arrive one bit clock after the edge that first sees the pulse. `fmt_i2s` high makes it arrive on that same edge.
- R9: The framing is decided again on every frame. A stream may switch from I2S frames to sync frames without a reset, and no spurious pair is produced at the switch.
- R10: `out_valid` stays high, with both samples stable, until `out_ready` is seen high. A pair that completes while one is still pending replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word clock / frame sync |
| sdata | input | 1 | Serial data, MSB first |
| fmt_i2s | input | 1 | 1: I2S and late-start sync framing; 0: right-justified and early-start sync framing |
| out_valid | output | 1 | A sample pair is available |
| out_ready | input | 1 | The consumer takes the pair |
| out_left | output | 24 | Left sample, left-aligned |
| out_right | output | 24 | Right sample, left-aligned |

## Verification
A wrong phase position or bit counter shows up as a sample shifted by one bit position, and it does so on the very next pair, within one frame. A stale sync-pulse decision shows up within one frame: either a pair goes missing or a junk pair appears. This matters most at a switch between framings. A pending flag that clears too early or never clears shows up within a few system clocks: either a pair is lost under back-pressure or one pair is seen twice.

// File: rtl/audrx_pkg.sv
package audrx_pkg;
  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;
endpackage

// File: rtl/audrx_front.sv
module audrx_front #(
  parameter int PHASE_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk,
  input  logic               lrclk,
  input  logic               sdata,
  output logic               tick,
  output logic               dat,
  output logic               lr,
  output logic               rise,
  output logic               fall,
  output logic [PHASE_W-1:0] prev_k,
  output logic               seen
);
  logic b_q, b_q2, l_q, d_q, lr_prev, primed;
  logic [PHASE_W-1:0] cnt, k_now;

  assign tick   = b_q & ~b_q2;
  assign dat    = d_q;
  assign lr     = l_q;
  assign rise   = tick & primed & l_q & ~lr_prev;
  assign fall   = tick & primed & ~l_q & lr_prev;
  assign prev_k = cnt;

  always_comb begin
    if (rise || fall)                 k_now = '0;
    else if (cnt == {PHASE_W{1'b1}})  k_now = cnt;
    else                              k_now = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q <= 1'b0; b_q2 <= 1'b0; l_q <= 1'b0; d_q <= 1'b0;
      lr_prev <= 1'b0; primed <= 1'b0; seen <= 1'b0; cnt <= '0;
    end else begin
      b_q  <= bclk;
      b_q2 <= b_q;
      l_q  <= lrclk;
      d_q  <= sdata;
      if (tick) begin
        primed  <= 1'b1;
        lr_prev <= l_q;
        cnt     <= k_now;
        if (rise || fall) seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audrx_word.sv
module audrx_word
  import audrx_pkg::*;
#(
  parameter int W        = 24,
  parameter int RJ_W     = 16,
  parameter int PHASE_W  = 7,
  parameter int SYNC_MAX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fmt_e               fmt,
  input  logic               tick,
  input  logic               dat,
  input  logic               rise,
  input  logic               fall,
  input  logic [PHASE_W-1:0] prev_k,
  input  logic               seen,
  output logic               emit,
  output logic [W-1:0]       left,
  output logic [W-1:0]       right
);
  localparam int NW  = $clog2(W + 1);
  localparam int PAD = W - RJ_W;

  logic [W-1:0]    sh, held_l, tail, aligned, rj_word;
  logic [NW-1:0]   n, nf;
  logic [RJ_W-1:0] rj_sh;
  logic            lok, room, long_hi;

  always_comb begin
    room    = (n < NW'(W));
    tail    = room ? {sh[W-2:0], dat} : sh;
    nf      = room ? n + 1'b1 : n;
    aligned = tail << (NW'(W) - nf);
    rj_word = {rj_sh, {PAD{1'b0}}};
    long_hi = (prev_k >= PHASE_W'(SYNC_MAX));
  end

  assign emit  = lok && ((fmt == FMT_I2S) ? (fall && long_hi) : rise);
  assign left  = held_l;
  assign right = (fmt == FMT_I2S) ? aligned : rj_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; n <= '0; rj_sh <= '0; held_l <= '0; lok <= 1'b0;
    end else if (tick) begin
      if (rise || fall) begin
        sh <= '0;
        n  <= '0;
      end else if (room) begin
        sh <= {sh[W-2:0], dat};
        n  <= n + 1'b1;
      end
      rj_sh <= {rj_sh[RJ_W-2:0], dat};
      if (fmt == FMT_I2S) begin
        if (rise) begin
          held_l <= aligned;
          lok    <= seen;
        end else if (fall) begin
          lok <= 1'b0;
        end
      end else begin
        if (fall) begin
          held_l <= rj_word;
          lok    <= seen && long_hi;
        end else if (rise) begin
          lok <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/audrx_dsp.sv
module audrx_dsp
  import audrx_pkg::*;
#(
  parameter int W        = 24,
  parameter int SLOT_W   = 16,
  parameter int PHASE_W  = 7,
  parameter int SYNC_MAX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fmt_e               fmt,
  input  logic               tick,
  input  logic               dat,
  input  logic               lr,
  input  logic               rise,
  input  logic               fall,
  input  logic [PHASE_W-1:0] prev_k,
  output logic               emit,
  output logic [W-1:0]       left,
  output logic [W-1:0]       right
);
  localparam int FR  = 2 * SLOT_W;
  localparam int PAD = W - SLOT_W;

  logic [PHASE_W-1:0] pos, pos_now, off;
  logic [FR-1:0]      sh, word;
  logic               armed, short_q, in_win, last;

  always_comb begin
    off = (fmt == FMT_I2S) ? '0 : PHASE_W'(1);
    if (rise)                         pos_now = '0;
    else if (pos == {PHASE_W{1'b1}})  pos_now = pos;
    else                              pos_now = pos + 1'b1;
    in_win = (pos_now >= off) && (pos_now < off + PHASE_W'(FR));
    last   = (pos_now == off + PHASE_W'(FR - 1));
    word   = {sh[FR-2:0], dat};
  end

  assign emit  = tick && armed && short_q && last;
  assign left  = {word[FR-1:SLOT_W], {PAD{1'b0}}};
  assign right = {word[SLOT_W-1:0], {PAD{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; sh <= '0; armed <= 1'b0; short_q <= 1'b0;
    end else if (tick) begin
      pos <= pos_now;
      if (in_win) sh <= word;
      if (rise) begin
        armed   <= 1'b1;
        short_q <= 1'b0;
      end else if (fall && armed && (prev_k < PHASE_W'(SYNC_MAX))) begin
        short_q <= 1'b1;
      end else if (emit) begin
        armed   <= 1'b0;
        short_q <= 1'b0;
      end
    end
  end

  // R7: a sync-frame pair completes only after the sync pulse has ended
  a_r7_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> !lr);
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import audrx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 16,
  parameter int SYNC_MAX = 4,
  parameter int PHASE_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdata,
  input  logic                fmt_i2s,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  fmt_e fmt;
  logic tick, dat, lr, rise, fall, seen;
  logic [PHASE_W-1:0] prev_k;
  logic emit_w, emit_d, load;
  logic [SAMPLE_W-1:0] w_l, w_r, d_l, d_r;

  assign fmt  = fmt_e'(fmt_i2s);
  assign load = emit_w || emit_d;

  audrx_front #(.PHASE_W(PHASE_W)) u_front (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .tick(tick), .dat(dat), .lr(lr), .rise(rise), .fall(fall),
    .prev_k(prev_k), .seen(seen)
  );

  audrx_word #(.W(SAMPLE_W), .RJ_W(SLOT_W), .PHASE_W(PHASE_W), .SYNC_MAX(SYNC_MAX)) u_word (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .tick(tick), .dat(dat),
    .rise(rise), .fall(fall), .prev_k(prev_k), .seen(seen),
    .emit(emit_w), .left(w_l), .right(w_r)
  );

  audrx_dsp #(.W(SAMPLE_W), .SLOT_W(SLOT_W), .PHASE_W(PHASE_W), .SYNC_MAX(SYNC_MAX)) u_dsp (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .tick(tick), .dat(dat), .lr(lr),
    .rise(rise), .fall(fall), .prev_k(prev_k),
    .emit(emit_d), .left(d_l), .right(d_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (emit_d) begin
      out_valid <= 1'b1;
      out_left  <= d_l;
      out_right <= d_r;
    end else if (emit_w) begin
      out_valid <= 1'b1;
      out_left  <= w_l;
      out_right <= w_r;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a pending pair is held until the consumer takes it
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !load |=> out_valid && $stable(out_left) && $stable(out_right));

  // R10: an accepted pair is not offered again
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load |=> !out_valid);

  // R9: the per-frame framing decision never lets both paths complete at once
  a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(emit_w && emit_d));

  // R2: pairs complete only on a sampled bit-clock rising edge
  a_r2_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> tick);
endmodule

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_B     = 4;
  localparam int SMAX       = 4096;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0, fmt_i2s = 1'b1;
  logic out_ready = 1'b0, out_valid;
  logic [23:0] out_left, out_right;

  pcm_serial_rx u_pcm_serial_rx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt_i2s(fmt_i2s), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  bit st_l [0:SMAX-1];
  bit st_d [0:SMAX-1];
  int st_n;
  logic [23:0] exp_l [0:63], exp_r [0:63], got_l [0:63], got_r [0:63];
  int exp_n = 0, got_n = 0;
  int rdy_mode = 0;  // 0 random, 1 held low, 2 held high
  logic r_next;

  always @(negedge clk) begin
    r_next = (rdy_mode == 0) ? 1'($urandom % 2) : (rdy_mode == 2);
    out_ready = r_next;
    if (out_valid && r_next && got_n < 64) begin
      got_l[got_n] = out_left;
      got_r[got_n] = out_right;
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] exp_i2s(input logic [31:0] d, input int wl);
    logic [31:0] m;
    m = (wl >= 32) ? d : (d & ~(32'hFFFF_FFFF >> wl));
    return m[31:8];
  endfunction

  task automatic seg_start();
    for (int i = 0; i < SMAX; i++) begin st_l[i] = 1'b0; st_d[i] = 1'b0; end
    st_n = 0; exp_n = 0; got_n = 0;
  endtask

  task automatic push_bits(input int n, input bit l);
    for (int i = 0; i < n; i++) begin st_l[st_n] = l; st_n++; end
  endtask

  task automatic add_exp(input logic [23:0] l, input logic [23:0] r);
    exp_l[exp_n] = l; exp_r[exp_n] = r; exp_n++;
  endtask

  task automatic i2s_frame(input logic [31:0] dl, input logic [31:0] dr, input int wl, input int p);
    int base;
    base = st_n;
    push_bits(p, 1'b0);
    push_bits(p, 1'b1);
    for (int i = 0; i < p; i++) begin
      st_d[base + 1 + i]     = (i < wl) ? dl[31 - i] : 1'b0;
      st_d[base + p + 1 + i] = (i < wl) ? dr[31 - i] : 1'b0;
    end
    add_exp(exp_i2s(dl, wl), exp_i2s(dr, wl));
  endtask

  task automatic rj_frame(input logic [15:0] dl, input logic [15:0] dr, input int p);
    int base;
    base = st_n;
    push_bits(p, 1'b1);
    push_bits(p, 1'b0);
    for (int j = 0; j < 16; j++) begin
      st_d[base + p - 16 + j]     = dl[15 - j];
      st_d[base + 2 * p - 16 + j] = dr[15 - j];
    end
    add_exp({dl, 8'h00}, {dr, 8'h00});
  endtask

  task automatic sync_frame(input logic [15:0] dl, input logic [15:0] dr, input int pulse, input bit late);
    int start;
    start = st_n + (late ? 0 : 1);
    push_bits(pulse, 1'b1);
    push_bits(64 - pulse, 1'b0);
    for (int j = 0; j < 32; j++)
      st_d[start + j] = (j < 16) ? dl[15 - j] : dr[31 - j];
    add_exp({dl, 8'h00}, {dr, 8'h00});
  endtask

  task automatic run_seg();
    for (int i = 0; i < st_n; i++) begin
      bclk = 1'b0; lrclk = st_l[i]; sdata = st_d[i];
      repeat (HALF_B) @(negedge clk);
      bclk = 1'b1;
      repeat (HALF_B) @(negedge clk);
    end
    bclk = 1'b0;
  endtask

  task automatic check_seg(input string req);
    repeat (40) @(negedge clk);
    chk(got_n == exp_n, {req, " pair count"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_l[i] == exp_l[i], {req, " left"}, 32'(got_l[i]), 32'(exp_l[i]));
      chk(got_r[i] == exp_r[i], {req, " right"}, 32'(got_r[i]), 32'(exp_r[i]));
    end
  endtask

  task automatic do_reset(input bit l0);
    rst_n = 1'b0; bclk = 1'b0; lrclk = l0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 0);
    chk(out_left == 24'h0 && out_right == 24'h0, "R1 samples in reset", 32'(out_left), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] rnd32();
    return $urandom;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1: reset state
    do_reset(1'b1);
    chk(out_valid == 1'b0, "R1 valid after release", 32'(out_valid), 0);

    // R2: 24-bit words in 32-clock phases
    fmt_i2s = 1'b1; seg_start(); push_bits(4, 1'b1);
    for (int f = 0; f < 3; f++) i2s_frame(rnd32() & 32'hFFFFFF00, rnd32() & 32'hFFFFFF00, 24, 32);
    i2s_frame(32'h80000100, 32'h00000100, 24, 24);
    push_bits(4, 1'b0); run_seg(); check_seg("R2");

    // R3: 32-bit words truncated
    do_reset(1'b1); seg_start(); push_bits(4, 1'b1);
    for (int f = 0; f < 3; f++) i2s_frame(rnd32(), rnd32(), 32, 32);
    push_bits(4, 1'b0); run_seg(); check_seg("R3");

    // R4: 20-bit words zero-padded in 24-clock phases
    do_reset(1'b1); seg_start(); push_bits(4, 1'b1);
    for (int f = 0; f < 3; f++) i2s_frame(rnd32(), rnd32(), 20, 24);
    push_bits(4, 1'b0); run_seg(); check_seg("R4");

    // R5: packed 16-bit phases
    do_reset(1'b1); seg_start(); push_bits(4, 1'b1);
    i2s_frame(32'hFFFF0000, 32'h00010000, 16, 16);
    for (int f = 0; f < 3; f++) i2s_frame(rnd32(), rnd32(), 16, 16);
    push_bits(4, 1'b0); run_seg(); check_seg("R5");

    // R2 R3 R4 R5: random mix of I2S word layouts in one stream
    do_reset(1'b1); seg_start(); push_bits(4, 1'b1);
    for (int f = 0; f < 8; f++) begin
      case ($urandom % 4)
        0: i2s_frame(rnd32(), rnd32(), 16, 16);
        1: i2s_frame(rnd32(), rnd32(), 20, 24);
        2: i2s_frame(rnd32(), rnd32(), 24, 32);
        default: i2s_frame(rnd32(), rnd32(), 32, 32);
      endcase
    end
    push_bits(4, 1'b0); run_seg(); check_seg("R2 mix");

    // R6: right-justified, various phase lengths
    fmt_i2s = 1'b0; do_reset(1'b0); seg_start(); push_bits(4, 1'b0);
    rj_frame(16'h8001, 16'h7FFE, 16);
    for (int f = 0; f < 5; f++) begin
      case ($urandom % 3)
        0: rj_frame(16'(rnd32()), 16'(rnd32()), 16);
        1: rj_frame(16'(rnd32()), 16'(rnd32()), 24);
        default: rj_frame(16'(rnd32()), 16'(rnd32()), 32);
      endcase
    end
    push_bits(4, 1'b1); run_seg(); check_seg("R6");

    // R7 R8: sync frames, early start (select low)
    fmt_i2s = 1'b0; do_reset(1'b0); seg_start(); push_bits(4, 1'b0);
    sync_frame(16'hA5C3, 16'h3C5A, 1, 1'b0);
    sync_frame(16'h8000, 16'h0001, 4, 1'b0);
    for (int f = 0; f < 3; f++) sync_frame(16'(rnd32()), 16'(rnd32()), 1 + int'($urandom % 4), 1'b0);
    push_bits(2, 1'b0); run_seg(); check_seg("R7 R8 early");

    // R7 R8: sync frames, late start (select high)
    fmt_i2s = 1'b1; do_reset(1'b0); seg_start(); push_bits(4, 1'b0);
    sync_frame(16'h0001, 16'h8000, 4, 1'b1);
    sync_frame(16'hFFFF, 16'h1234, 1, 1'b1);
    for (int f = 0; f < 3; f++) sync_frame(16'(rnd32()), 16'(rnd32()), 1 + int'($urandom % 4), 1'b1);
    push_bits(2, 1'b0); run_seg(); check_seg("R7 R8 late");

    // R9: I2S frames then sync frames without reset
    fmt_i2s = 1'b1; do_reset(1'b1); seg_start(); push_bits(4, 1'b1);
    for (int f = 0; f < 2; f++) i2s_frame(rnd32(), rnd32(), 24, 32);
    push_bits(8, 1'b0);
    for (int f = 0; f < 2; f++) sync_frame(16'(rnd32()), 16'(rnd32()), 2, 1'b1);
    push_bits(2, 1'b0); run_seg(); check_seg("R9");

    // R10: back-pressure keeps only the newest pair
    do_reset(1'b1); rdy_mode = 1; seg_start(); push_bits(4, 1'b1);
    for (int f = 0; f < 3; f++) i2s_frame(rnd32(), rnd32(), 24, 32);
    push_bits(4, 1'b0);
    exp_l[0] = exp_l[exp_n-1]; exp_r[0] = exp_r[exp_n-1]; exp_n = 1;
    run_seg();
    repeat (50) @(negedge clk);
    chk(out_valid == 1'b1, "R10 valid held", 32'(out_valid), 1);
    chk(out_left == exp_l[0], "R10 newest left held", 32'(out_left), 32'(exp_l[0]));
    chk(out_right == exp_r[0], "R10 newest right held", 32'(out_right), 32'(exp_r[0]));
    rdy_mode = 2;
    check_seg("R10");
    chk(out_valid == 1'b0, "R10 valid dropped after accept", 32'(out_valid), 0);
    rdy_mode = 0;

    finish_run();
  end
endmodule